// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

This block connects an on-chip host to an external asynchronous static RAM of 32768 sixteen-bit words. The host presents one request at a time over a valid/ready handshake: a word address, a write flag, write data and two byte enables. Bit 0 of the byte enable selects the low byte (data bits 7:0). Bit 1 selects the high byte (data bits 15:8). Reads come back on a separate data port, marked by a single-cycle valid pulse.

On the memory side the controller drives active-low chip select, write strobe, output enable and two byte-lane strobes, plus the address. The data bus is split into an output value, an output-enable and an input value, so the pad cell can sit outside the block. Each access runs through four phases. In the setup phase, address, data and lane strobes are presented with chip select low. The strobe phase follows, with the write strobe or the output enable low for a programmed number of clocks. In the hold phase every strobe is high and the address and write data stay put. The controller then returns to idle. The clock counts for the read wait, the write pulse and the turnaround are parameters, chosen from the clock period and the memory's speed grade.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, req_ready is 1, rsp_valid is 0, mem_dq_oe is 0 and all five memory strobes are 1.
- R2: A write with at least one byte enable set drives mem_we_n low for exactly WR_PULSE consecutive cycles. During that time mem_cs_n is low, mem_lb_n is low exactly when be[0] is set, mem_ub_n is low exactly when be[1] is set, mem_oe_n stays high, and mem_dq_oe is high.
- R3: From chip select falling until all strobes are high again, mem_addr equals the requested address and does not change. While mem_we_n is low, mem_dq_out equals the write data and does not change. The data is driven at least one cycle before mem_we_n falls.
- R4: A read with at least one byte enable set drives mem_oe_n low for exactly RD_WAIT consecutive cycles. During that time mem_we_n stays high and mem_dq_oe stays low.
- R5: A read returns one rsp_valid pulse, RD_WAIT+2 falling clock edges after the edge that accepted it. rsp_rdata carries the memory byte on each enabled lane and zero on each disabled lane.
- R6: After the strobes end, every strobe stays high for TURN_IDLE cycles before req_ready returns. req_ready is high only when no access is in progress, and then chip select is high.
- R7: A request with both byte enables clear asserts no memory strobe and leaves req_ready high. For a read, rsp_valid pulses with rsp_rdata zero on the first falling edge after acceptance.
- R8: A single-lane write changes only its own byte of the addressed word. A later full read returns the other byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; a request is taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lb_n | output | 1 | Low-byte strobe, active low |
| mem_ub_n | output | 1 | High-byte strobe, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The bench attaches a cycle-counting memory model that measures every write-strobe and output-enable pulse. A controller with an off-by-one counter would show pulses one cycle short or long. The model also flags an address or write-data change under an active strobe, and any cycle where output enable is low while the controller drives the bus, which is the bus contention a wrong turnaround would cause. The model returns filler on unselected lanes, so a design that skipped the lane mask would leak that filler into rsp_rdata. Directed cases cover:
- single-lane writes followed by full reads, where a design that wrote both lanes would corrupt the neighbouring byte;
- zero-enable requests, which must produce no chip-select pulse;
- response and ready latencies, counted against the parameters.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic              write;
        logic [LANES-1:0]  be;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } access_t;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < LANES; i++) begin
            m[i*LANE_W +: LANE_W] = {LANE_W{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int RD_WAIT   = 2,
    parameter int WR_PULSE  = 2,
    parameter int TURN_IDLE = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   is_write,
    output phase_e phase,
    output logic   strobe_last
);
    localparam int MAX_A = (RD_WAIT > WR_PULSE) ? RD_WAIT : WR_PULSE;
    localparam int MAX_C = (MAX_A > TURN_IDLE) ? MAX_A : TURN_IDLE;
    localparam int CW    = (MAX_C < 2) ? 1 : $clog2(MAX_C);
    localparam logic [CW-1:0] RD_LOAD = CW'(RD_WAIT - 1);
    localparam logic [CW-1:0] WR_LOAD = CW'(WR_PULSE - 1);
    localparam logic [CW-1:0] TN_LOAD = CW'(TURN_IDLE - 1);

    phase_e        ph_q, ph_d;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          expired;

    asram_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    always_comb begin
        ph_d   = ph_q;
        ld     = 1'b0;
        ld_val = '0;
        unique case (ph_q)
            PH_IDLE:   if (start) ph_d = PH_SETUP;
            PH_SETUP: begin
                ph_d   = PH_STROBE;
                ld     = 1'b1;
                ld_val = is_write ? WR_LOAD : RD_LOAD;
            end
            PH_STROBE: if (expired) begin
                ph_d   = PH_HOLD;
                ld     = 1'b1;
                ld_val = TN_LOAD;
            end
            PH_HOLD:   if (expired) ph_d = PH_IDLE;
            default:   ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    assign phase       = ph_q;
    assign strobe_last = (ph_q == PH_STROBE) && expired;
endmodule

// File: rtl/asram_rdret.sv
module asram_rdret
    import asram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              zero_rsp,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [DATA_W-1:0] masked;

    assign masked = dq_in & lane_mask(be);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture || zero_rsp;
            if (capture)       rsp_rdata <= masked;
            else if (zero_rsp) rsp_rdata <= '0;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int RD_WAIT   = 2,
    parameter int WR_PULSE  = 2,
    parameter int TURN_IDLE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    phase_e           phase;
    access_t          acc_q;
    logic             accept, no_lane, start, zero_rsp, capture;
    logic             strobe_last, active;
    logic [LANES-1:0] lane_n;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign no_lane   = (req_be == '0);
    assign start     = accept && !no_lane;
    assign zero_rsp  = accept && no_lane && !req_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (start) begin
            acc_q.write <= req_write;
            acc_q.be    <= req_be;
            acc_q.addr  <= req_addr;
            acc_q.wdata <= req_wdata;
        end
    end

    asram_fsm #(
        .RD_WAIT   (RD_WAIT),
        .WR_PULSE  (WR_PULSE),
        .TURN_IDLE (TURN_IDLE)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .is_write    (acc_q.write),
        .phase       (phase),
        .strobe_last (strobe_last)
    );

    assign capture = strobe_last && !acc_q.write;

    asram_rdret u_rdret (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .zero_rsp  (zero_rsp),
        .be        (acc_q.be),
        .dq_in     (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign active = (phase == PH_SETUP) || (phase == PH_STROBE);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n[g] = !(active && acc_q.be[g]);
    end

    assign mem_cs_n   = !active;
    assign mem_lb_n   = lane_n[0];
    assign mem_ub_n   = lane_n[LANES-1];
    assign mem_we_n   = !((phase == PH_STROBE) && acc_q.write);
    assign mem_oe_n   = !((phase == PH_STROBE) && !acc_q.write);
    assign mem_addr   = acc_q.addr;
    assign mem_dq_out = acc_q.wdata;
    assign mem_dq_oe  = acc_q.write && (phase != PH_IDLE);
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk
    import asram_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    AST_OE_NOT_WITH_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);                                   // R4
    AST_OE_NOT_WITH_WE: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> mem_we_n);                                     // R4
    AST_WE_HAS_LANE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && (!mem_lb_n || !mem_ub_n) && mem_dq_oe)); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));      // R3
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));    // R3
    AST_WE_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(mem_dq_oe));                       // R3
    AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n)); // R6
endmodule

bind asram_ctrl asram_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_lb_n   (mem_lb_n),
    .mem_ub_n   (mem_ub_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int RD = 3;
    localparam int WR = 2;
    localparam int TN = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [14:0] mem_addr;
    logic [15:0] mem_dq_out, mem_dq_in;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [15:0] sram   [0:255];
    logic [15:0] shadow [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_ctrl #(.RD_WAIT(RD), .WR_PULSE(WR), .TURN_IDLE(TN)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] bmask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // asynchronous memory model; unselected lanes and idle bus read as filler
    wire rd_act = !mem_cs_n && mem_we_n && !mem_oe_n;
    assign mem_dq_in = rd_act ?
        {mem_ub_n ? 8'hA5 : sram[mem_addr[7:0]][15:8], mem_lb_n ? 8'h5A : sram[mem_addr[7:0]][7:0]}
        : 16'hC3C3;

    logic        p_wr = 0, p_we_low = 0, p_oe_low = 0, p_cs_low = 0, p_lb = 1, p_ub = 1;
    logic [14:0] p_addr = '0;
    logic [15:0] p_data = '0;
    int we_cnt = 0, oe_cnt = 0, cs_falls = 0;
    logic [14:0] seen_addr = '0;

    always @(negedge clk) begin
        logic wr_act;
        wr_act = !mem_cs_n && !mem_we_n && (!mem_lb_n || !mem_ub_n);
        if (p_wr && !wr_act) begin
            if (!p_lb) sram[p_addr[7:0]][7:0]  = p_data[7:0];
            if (!p_ub) sram[p_addr[7:0]][15:8] = p_data[15:8];
        end
        if (!mem_cs_n && !p_cs_low) begin
            cs_falls++;
            seen_addr = mem_addr;
        end
        if (!mem_cs_n && p_cs_low && mem_addr != p_addr)
            chk(0, "R3 address moved under chip select", {17'd0, mem_addr}, {17'd0, p_addr});
        if (!mem_we_n && p_we_low && mem_dq_out != p_data)
            chk(0, "R3 write data moved under write strobe", {16'd0, mem_dq_out}, {16'd0, p_data});
        if (!mem_oe_n && mem_dq_oe)
            chk(0, "R4 bus contention", 32'd1, 32'd0);
        if (!mem_we_n) we_cnt++;
        if (!mem_oe_n) oe_cnt++;
        if (p_we_low && mem_we_n) begin
            chk(we_cnt == WR, "R2 write pulse width", we_cnt, WR);
            we_cnt = 0;
        end
        if (p_oe_low && mem_oe_n) begin
            chk(oe_cnt == RD, "R4 output enable width", oe_cnt, RD);
            oe_cnt = 0;
        end
        p_wr = wr_act; p_we_low = !mem_we_n; p_oe_low = !mem_oe_n;
        p_cs_low = !mem_cs_n; p_lb = mem_lb_n; p_ub = mem_ub_n;
        p_addr = mem_addr; p_data = mem_dq_out;
    end

    // R2 lane strobes during the write pulse follow the byte enables
    logic [1:0] cur_be = '0;
    logic       cur_wr = 0;
    always @(negedge clk) begin
        if (!mem_we_n) begin
            chk({!mem_ub_n, !mem_lb_n} == cur_be && !mem_cs_n && mem_oe_n && mem_dq_oe,
                "R2 lane strobes in write", {28'd0, !mem_ub_n, !mem_lb_n, mem_cs_n, mem_oe_n},
                {28'd0, cur_be, 2'b01});
        end
        if (!mem_oe_n) begin
            chk({!mem_ub_n, !mem_lb_n} == cur_be && mem_we_n && !mem_dq_oe,
                "R4 lane strobes in read", {30'd0, !mem_ub_n, !mem_lb_n}, {30'd0, cur_be});
        end
    end

    task automatic host_op(input bit wr, input logic [14:0] a, input logic [15:0] d,
                           input logic [1:0] be, output logic [15:0] rd,
                           output int rsp_lat, output int rdy_lat);
        bit got;
        got = 0; rd = '0; rsp_lat = -1; rdy_lat = -1;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        cur_be = be; cur_wr = wr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        for (int k = 1; k < 80; k++) begin
            if (rsp_valid && !got) begin
                got = 1; rd = rsp_rdata; rsp_lat = k;
            end
            if (req_ready) begin
                rdy_lat = k;
                break;
            end
            @(negedge clk);
        end
        if (!got && !wr) begin
            for (int k = 0; k < 3; k++) begin
                if (rsp_valid && !got) begin got = 1; rd = rsp_rdata; rsp_lat = rdy_lat + k; end
                @(negedge clk);
            end
        end
        if (wr) begin
            if (be[0]) shadow[a[7:0]][7:0]  = d[7:0];
            if (be[1]) shadow[a[7:0]][15:8] = d[15:8];
        end
    endtask

    task automatic do_write(input logic [14:0] a, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] rd; int rl, yl, cf;
        cf = cs_falls;
        host_op(1, a, d, be, rd, rl, yl);
        if (be == 2'b00) begin
            chk(cs_falls == cf, "R7 zero-lane write strobes", cs_falls - cf, 0);
            chk(yl == 1, "R7 zero-lane write ready", yl, 1);
        end else begin
            chk(seen_addr == a, "R3 write address", {17'd0, seen_addr}, {17'd0, a});
            chk(yl == WR + TN + 2, "R6 write turnaround", yl, WR + TN + 2);
        end
    endtask

    task automatic do_read(input logic [14:0] a, input logic [1:0] be, input string tag);
        logic [15:0] rd, exp; int rl, yl, cf;
        cf = cs_falls;
        host_op(0, a, '0, be, rd, rl, yl);
        exp = shadow[a[7:0]] & bmask(be);
        chk(rd == exp, tag, {16'd0, rd}, {16'd0, exp});
        if (be == 2'b00) begin
            chk(rl == 1 && cs_falls == cf, "R7 zero-lane read response", rl, 1);
        end else begin
            chk(rl == RD + 2, "R5 read latency", rl, RD + 2);
            chk(yl == RD + TN + 2, "R6 read turnaround", yl, RD + TN + 2);
            chk(seen_addr == a, "R3 read address", {17'd0, seen_addr}, {17'd0, a});
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(0, "watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 256; i++) begin
            sram[i] = 16'(i * 16'h0101 ^ 16'h3C96);
            shadow[i] = sram[i];
        end
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_dq_oe, "R1 reset handshake",
            {29'd0, req_ready, rsp_valid, mem_dq_oe}, 32'h4);
        chk({mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'h1F, "R1 reset strobes",
            {27'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 32'h1F);
        rst = 0;
        @(negedge clk);
        chk(req_ready && mem_cs_n && !rsp_valid, "R1 after reset",
            {30'd0, req_ready, mem_cs_n}, 32'h3);

        do_write(15'h1234, 16'hBEEF, 2'b11);
        do_read (15'h1234, 2'b11, "R5 full read");
        do_write(15'h0034, 16'h1177, 2'b01);
        do_read (15'h0034, 2'b11, "R8 low-lane write keeps high byte");
        do_write(15'h0034, 16'h99AA, 2'b10);
        do_read (15'h0034, 2'b11, "R8 high-lane write keeps low byte");
        do_read (15'h0034, 2'b10, "R5 high-lane read zeroes low byte");
        do_read (15'h0034, 2'b01, "R5 low-lane read zeroes high byte");
        do_write(15'h0034, 16'h0000, 2'b00);
        do_read (15'h0034, 2'b11, "R7 zero-lane write left word");
        do_read (15'h0034, 2'b00, "R7 zero-lane read data");
        do_read (15'h7FFF, 2'b11, "R5 top address read");

        for (int n = 0; n < 60; n++) begin
            logic [14:0] a;
            logic [1:0]  be;
            a  = {7'($urandom), 8'($urandom_range(0, 15))};
            be = 2'($urandom);
            if ($urandom_range(0, 1) == 1) do_write(a, 16'($urandom), be);
            else                           do_read(a, be, "R5 random read");
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule